// File: doc/BRIEF.md
# Phase-Programmable Multi-Bank Clock Generator

This block stands in for the output stage of a multi-phase clock buffer. It runs on a fast sampling clock whose rate is MF times the reference rate, so one sampling period equals one skew time unit (tU). A phase counter tracks the position inside the reference cycle. From it the block builds four banks of two outputs each. Each bank can be shifted by a signed number of tU, divided down, or inverted, depending on its own pair of three-level select inputs.

A three-level range select sets MF. A three-level edge select aligns all waveforms either to the rising or to the falling edge of the reference. A test input bypasses the phase logic: the first two banks then carry an external reference input directly, and the last two carry it through their dividers. Select changes are taken only at a reference-cycle boundary.

Top module: `phase_clkgen`

## Requirements
- R1: There are four banks (b1..b4), each driving two outputs that are always equal to each other.
- R2: Every three-level input uses 00 = L, 01 = M, 10 = H, with 11 read as M. `range_sel` L/M/H gives MF = 32/16/8 sampling cycles per reference period. A non-divided output has a period of MF cycles and is high for half of it.
- R3: Each bank select is `{first, second}` levels in bits [3:2] and [1:0]. For b1 and b2, the pair index 3*first+second (0..8) gives a skew of index−4 tU (LL = −4 up to HH = +4). A skew of n delays the rising edge by n cycles. A negative n delays it by MF+n cycles.
- R4: For b3, the codes LM..HM (index 1..7) give a skew of 2*(index−4) tU. LL divides by 2 (period 2*MF) and HH divides by 4 (period 4*MF). All divided outputs have a 50% duty cycle.
- R5: For b4, LM..HM give the same skews as b3. LL divides by 2, and HH gives the zero-skew waveform inverted (rising edge MF/2 cycles after the zero-skew rising edge).
- R6: `edge_sel` = L delays every waveform by MF/2 cycles, which aligns it to the falling reference edge. M and H give rising alignment.
- R7: A new value on `range_sel`, `edge_sel` or any bank select is taken only at the end of a reference cycle, when the low log2(MF) bits of the phase counter are all ones. Inside a reference cycle the outputs keep following the previous setting.
- R8: Divided outputs are phase-aligned to the phase counter. A divide-by-D output rises at phase positions that are multiples of D*MF, plus the edge-select delay.
- R9: With `test_en` = 1, b1 and b2 show `ref_in` one clock later. b3 divides `ref_in` rising edges by K (LL: 2, HH: 4, otherwise 1) and b4 divides them by M (LL: 2, otherwise 1). A divided output changes on the clock edge that samples a reference rise. Counting rises from reset, it is high after rise counts 1 mod 2 (K or M = 2) or 2 and 3 mod 4 (K = 4).
- R10: While `rst_n` is low, all outputs are 0 and the phase counter is 0. The first clock edge after release loads the selects. The sample taken after the k-th following edge shows phase position k−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one period per tU |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_sel | input | 2 | Three-level MF select |
| edge_sel | input | 2 | Three-level reference edge alignment select |
| test_en | input | 1 | Bypass of the phase logic |
| ref_in | input | 1 | Reference input used in bypass |
| sel_b1 | input | 4 | Bank 1 select pair |
| sel_b2 | input | 4 | Bank 2 select pair |
| sel_b3 | input | 4 | Bank 3 select pair |
| sel_b4 | input | 4 | Bank 4 select pair |
| q_b1 | output | OUTS | Bank 1 outputs |
| q_b2 | output | OUTS | Bank 2 outputs |
| q_b3 | output | OUTS | Bank 3 outputs |
| q_b4 | output | OUTS | Bank 4 outputs |

## Verification
Each vector fixes a range, an edge alignment and four bank codes, then locates every bank's rising edge and duty inside one full period after the first one. Negative codes are checked against their positive counterparts to confirm the wrap to MF+n. Divide and invert codes are paired with both edge settings, so a half-period shift cannot be mistaken for an inversion. The code 11 is applied on each three-level input to confirm it is read as M. Directed runs change a bank code in mid-cycle to show it is held until the boundary, and pulse `ref_in` in bypass to show the K and M counts.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam logic [1:0] LVL_LO  = 2'b00;
  localparam logic [1:0] LVL_MID = 2'b01;
  localparam logic [1:0] LVL_HI  = 2'b10;

  localparam int KIND_STEP1 = 0;  // unit skew steps only
  localparam int KIND_DIV   = 1;  // double steps, divide-by-2 / divide-by-4
  localparam int KIND_INV   = 2;  // double steps, divide-by-2 / inverted

  typedef enum logic [1:0] {ACT_SKEW, ACT_DIV2, ACT_DIV4, ACT_INV} bank_act_e;

  typedef struct packed {
    bank_act_e   act;
    logic [3:0]  skew;   // two's complement tU count
  } bank_dec_t;

  function automatic logic [1:0] level_norm(input logic [1:0] raw);
    return (raw == 2'b11) ? LVL_MID : raw;
  endfunction

  function automatic bank_dec_t bank_decode(input logic [3:0] code, input int kind);
    bank_dec_t d;
    int idx;
    idx = 3 * int'(level_norm(code[3:2])) + int'(level_norm(code[1:0]));
    d.act  = ACT_SKEW;
    d.skew = 4'd0;
    if (kind == KIND_STEP1)
      d.skew = 4'(idx - 4);
    else if (idx == 0)
      d.act = ACT_DIV2;
    else if (idx == 8)
      d.act = (kind == KIND_DIV) ? ACT_DIV4 : ACT_INV;
    else
      d.skew = 4'(2 * (idx - 4));
    return d;
  endfunction

endpackage

// File: rtl/pcg_phase.sv
module pcg_phase #(
  parameter int TW         = 7,
  parameter int MLW        = 3,
  parameter int MF_LOG_LO  = 5,
  parameter int MF_LOG_MID = 4,
  parameter int MF_LOG_HI  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     range_sel,
  input  logic [1:0]     edge_sel,
  output logic [TW-1:0]  tick,
  output logic           load,
  output logic [MLW-1:0] mf_log,
  output logic           half_shift
);
  import pcg_pkg::*;

  logic           primed, primed_nxt;
  logic [TW-1:0]  tick_nxt, cyc_mask;
  logic [MLW-1:0] mf_log_in, mf_log_nxt;
  logic           half_nxt, boundary;

  always_comb begin
    case (level_norm(range_sel))
      LVL_LO:  mf_log_in = MLW'(MF_LOG_LO);
      LVL_HI:  mf_log_in = MLW'(MF_LOG_HI);
      default: mf_log_in = MLW'(MF_LOG_MID);
    endcase
    cyc_mask   = ~({TW{1'b1}} << mf_log);
    boundary   = (tick & cyc_mask) == cyc_mask;
    load       = !primed || boundary;
    tick_nxt   = primed ? tick + TW'(1) : '0;
    mf_log_nxt = load ? mf_log_in : mf_log;
    half_nxt   = load ? (level_norm(edge_sel) == LVL_LO) : half_shift;
    primed_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick       <= '0;
      primed     <= 1'b0;
      mf_log     <= MLW'(MF_LOG_LO);
      half_shift <= 1'b0;
    end else begin
      tick       <= tick_nxt;
      primed     <= primed_nxt;
      mf_log     <= mf_log_nxt;
      half_shift <= half_nxt;
    end
  end

endmodule

// File: rtl/pcg_bank.sv
module pcg_bank #(
  parameter int KIND = 0,
  parameter int TW   = 7,
  parameter int MLW  = 3,
  parameter int OUTS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TW-1:0]   tick,
  input  logic [MLW-1:0]  mf_log,
  input  logic            half_shift,
  input  logic            test_en,
  input  logic            ref_in,
  input  logic            ref_rise,
  input  logic [3:0]      sel,
  output logic [OUTS-1:0] q
);
  import pcg_pkg::*;

  localparam int PW = TW + 1;

  logic [3:0]    code_r, code_nxt;
  bank_dec_t     dec;
  logic [1:0]    div_log;
  logic [MLW:0]  p_log;
  logic [PW-1:0] mf_v, p_v, mask, skew_ext, skew_t, half_t, off, pos;
  logic          hi, wave, twave, q_d;
  logic [1:0]    dcnt, dcnt_nxt;

  always_comb begin
    code_nxt = load ? sel : code_r;
    dec      = bank_decode(code_r, KIND);
    case (dec.act)
      ACT_DIV2: div_log = 2'd1;
      ACT_DIV4: div_log = 2'd2;
      default:  div_log = 2'd0;
    endcase
    p_log    = {1'b0, mf_log} + (MLW+1)'(div_log);
    mf_v     = PW'(1) << mf_log;
    p_v      = PW'(1) << p_log;
    mask     = p_v - PW'(1);
    skew_ext = {{(PW-4){dec.skew[3]}}, dec.skew};
    // a lead of n is realised as a lag of MF-n
    skew_t   = dec.skew[3] ? mf_v + skew_ext : skew_ext;
    half_t   = half_shift ? (mf_v >> 1) : '0;
    off      = half_t + ((dec.act == ACT_INV) ? '0 : skew_t);
    pos      = ({1'b0, tick} - off) & mask;
    hi       = pos < (p_v >> 1);
    wave     = (dec.act == ACT_INV) ? ~hi : hi;
    dcnt_nxt = ref_rise ? dcnt + 2'd1 : dcnt;
    case (div_log)
      2'd1:    twave = dcnt_nxt[0];
      2'd2:    twave = dcnt_nxt[1];
      default: twave = ref_in;
    endcase
    q_d = test_en ? twave : wave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_r <= 4'b0101;
      dcnt   <= 2'd0;
    end else begin
      code_r <= code_nxt;
      dcnt   <= dcnt_nxt;
    end
  end

  for (genvar o = 0; o < OUTS; o++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[o] <= 1'b0;
      else        q[o] <= q_d;
    end
  end

endmodule

// File: rtl/phase_clkgen.sv
module phase_clkgen #(
  parameter int OUTS       = 2,
  parameter int MF_LOG_LO  = 5,
  parameter int MF_LOG_MID = 4,
  parameter int MF_LOG_HI  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      range_sel,
  input  logic [1:0]      edge_sel,
  input  logic            test_en,
  input  logic            ref_in,
  input  logic [3:0]      sel_b1,
  input  logic [3:0]      sel_b2,
  input  logic [3:0]      sel_b3,
  input  logic [3:0]      sel_b4,
  output logic [OUTS-1:0] q_b1,
  output logic [OUTS-1:0] q_b2,
  output logic [OUTS-1:0] q_b3,
  output logic [OUTS-1:0] q_b4
);
  import pcg_pkg::*;

  localparam int NUM_BANKS = 4;
  localparam int TW        = MF_LOG_LO + 2;   // room for a divide-by-4 period
  localparam int MLW       = $clog2(MF_LOG_LO + 1);

  logic [TW-1:0]   tick;
  logic            load;
  logic [MLW-1:0]  mf_log;
  logic            half_shift;
  logic            ref_s, ref_rise;
  logic [3:0]      sel_arr [NUM_BANKS];
  logic [OUTS-1:0] q_arr   [NUM_BANKS];

  pcg_phase #(
    .TW(TW), .MLW(MLW),
    .MF_LOG_LO(MF_LOG_LO), .MF_LOG_MID(MF_LOG_MID), .MF_LOG_HI(MF_LOG_HI)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .edge_sel(edge_sel),
    .tick(tick), .load(load), .mf_log(mf_log), .half_shift(half_shift)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_s <= 1'b0;
    else        ref_s <= ref_in;
  end

  always_comb ref_rise = ref_in & ~ref_s;

  assign sel_arr[0] = sel_b1;
  assign sel_arr[1] = sel_b2;
  assign sel_arr[2] = sel_b3;
  assign sel_arr[3] = sel_b4;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int KIND = (b == 2) ? KIND_DIV : ((b == 3) ? KIND_INV : KIND_STEP1);
    pcg_bank #(.KIND(KIND), .TW(TW), .MLW(MLW), .OUTS(OUTS)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(load), .tick(tick), .mf_log(mf_log),
      .half_shift(half_shift), .test_en(test_en), .ref_in(ref_in),
      .ref_rise(ref_rise), .sel(sel_arr[b]), .q(q_arr[b])
    );
  end

  assign q_b1 = q_arr[0];
  assign q_b2 = q_arr[1];
  assign q_b3 = q_arr[2];
  assign q_b4 = q_arr[3];

endmodule

// File: rtl/pcg_chk.sv
module pcg_chk #(
  parameter int TW         = 7,
  parameter int MLW        = 3,
  parameter int OUTS       = 2,
  parameter int MF_LOG_LO  = 5,
  parameter int MF_LOG_MID = 4,
  parameter int MF_LOG_HI  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            test_en,
  input logic            ref_in,
  input logic [OUTS-1:0] q_b1,
  input logic [OUTS-1:0] q_b2,
  input logic [OUTS-1:0] q_b3,
  input logic [OUTS-1:0] q_b4,
  input logic [TW-1:0]   tick,
  input logic            load,
  input logic [MLW-1:0]  mf_log,
  input logic            half_shift
);

  assert_pair_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    q_b1 == {OUTS{q_b1[0]}} && q_b2 == {OUTS{q_b2[0]}} &&
    q_b3 == {OUTS{q_b3[0]}} && q_b4 == {OUTS{q_b4[0]}});

  assert_mf_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mf_log == MLW'(MF_LOG_LO) || mf_log == MLW'(MF_LOG_MID) || mf_log == MLW'(MF_LOG_HI));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mf_log) && $stable(half_shift));

  assert_bypass_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |=> q_b1 == {OUTS{$past(ref_in)}} && q_b2 == {OUTS{$past(ref_in)}});

  assert_tick_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick != '0) |=> tick == TW'($past(tick) + 1));

endmodule

bind phase_clkgen pcg_chk #(
  .TW(TW), .MLW(MLW), .OUTS(OUTS),
  .MF_LOG_LO(MF_LOG_LO), .MF_LOG_MID(MF_LOG_MID), .MF_LOG_HI(MF_LOG_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .ref_in(ref_in),
  .q_b1(q_b1), .q_b2(q_b2), .q_b3(q_b3), .q_b4(q_b4),
  .tick(tick), .load(load), .mf_log(mf_log), .half_shift(half_shift)
);

// File: tb/phase_clkgen_test.sv
module phase_clkgen_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 11;
  localparam int NSMP       = 260;

  // {range, edge, sel_b1, sel_b2, sel_b3, sel_b4, {period, rise} x 4}
  localparam logic [83:0] VECS [NVEC] = '{
    {2'b00, 2'b10, 4'b0101, 4'b0101, 4'b0101, 4'b0101, 8'd32, 8'd0,  8'd32, 8'd0,  8'd32,  8'd0,  8'd32, 8'd0},
    {2'b00, 2'b10, 4'b0000, 4'b1010, 4'b0001, 4'b1001, 8'd32, 8'd28, 8'd32, 8'd4,  8'd32,  8'd26, 8'd32, 8'd6},
    {2'b01, 2'b01, 4'b0001, 4'b1000, 4'b0000, 4'b0000, 8'd16, 8'd13, 8'd16, 8'd2,  8'd32,  8'd0,  8'd32, 8'd0},
    {2'b10, 2'b10, 4'b0100, 4'b0110, 4'b1010, 4'b1010, 8'd8,  8'd7,  8'd8,  8'd1,  8'd32,  8'd0,  8'd8,  8'd4},
    {2'b00, 2'b00, 4'b0101, 4'b0010, 4'b1010, 4'b1010, 8'd32, 8'd16, 8'd32, 8'd14, 8'd128, 8'd16, 8'd32, 8'd0},
    {2'b10, 2'b00, 4'b1001, 4'b0000, 4'b0100, 4'b0001, 8'd8,  8'd7,  8'd8,  8'd0,  8'd8,   8'd2,  8'd8,  8'd6},
    {2'b11, 2'b11, 4'b1111, 4'b1011, 4'b1000, 4'b0110, 8'd16, 8'd0,  8'd16, 8'd3,  8'd16,  8'd4,  8'd16, 8'd2},
    {2'b01, 2'b10, 4'b0010, 4'b1010, 4'b1001, 4'b0010, 8'd16, 8'd14, 8'd16, 8'd4,  8'd16,  8'd6,  8'd16, 8'd12},
    {2'b10, 2'b00, 4'b1010, 4'b0001, 4'b0000, 4'b0000, 8'd8,  8'd0,  8'd8,  8'd1,  8'd16,  8'd4,  8'd16, 8'd4},
    {2'b01, 2'b00, 4'b0000, 4'b0100, 4'b0001, 4'b1010, 8'd16, 8'd4,  8'd16, 8'd7,  8'd16,  8'd2,  8'd16, 8'd0},
    {2'b01, 2'b10, 4'b0101, 4'b0101, 4'b1010, 4'b0000, 8'd16, 8'd0,  8'd16, 8'd0,  8'd64,  8'd0,  8'd32, 8'd0}
  };

  logic       clk, rst_n, test_en, ref_in;
  logic [1:0] range_sel, edge_sel;
  logic [3:0] sel_b1, sel_b2, sel_b3, sel_b4;
  logic [1:0] q_b1, q_b2, q_b3, q_b4;
  logic [3:0] smp [NSMP];
  int         total, bad, pair_bad;
  bit         done;

  phase_clkgen uut (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .edge_sel(edge_sel),
    .test_en(test_en), .ref_in(ref_in),
    .sel_b1(sel_b1), .sel_b2(sel_b2), .sel_b3(sel_b3), .sel_b4(sel_b4),
    .q_b1(q_b1), .q_b2(q_b2), .q_b3(q_b3), .q_b4(q_b4)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] rng, input logic [1:0] edg, input logic tst,
                       input logic [3:0] s1, input logic [3:0] s2,
                       input logic [3:0] s3, input logic [3:0] s4);
    rst_n = 1'b0;
    range_sel = rng; edge_sel = edg; test_en = tst; ref_in = 1'b0;
    sel_b1 = s1; sel_b2 = s2; sel_b3 = s3; sel_b4 = s4;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);   // first edge after release: selects are loaded
  endtask

  task automatic grab(input int k);
    smp[k] = {q_b4[0], q_b3[0], q_b2[0], q_b1[0]};
    if (q_b1[0] != q_b1[1] || q_b2[0] != q_b2[1] ||
        q_b3[0] != q_b3[1] || q_b4[0] != q_b4[1]) pair_bad++;
  endtask

  function automatic string tag_of(input logic [1:0] edg, input int b, input int p, input int mf);
    if (edg == 2'b00) return "R6";
    if (p != mf)      return "R8";
    if (b < 2)        return "R3";
    if (b == 2)       return "R4";
    return "R5";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
    if (!done) $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; test_en = 1'b0; ref_in = 1'b0;
    range_sel = 2'b00; edge_sel = 2'b10;
    sel_b1 = 4'b0101; sel_b2 = 4'b0101; sel_b3 = 4'b0101; sel_b4 = 4'b0101;

    // R10: outputs held low during reset
    repeat (3) @(negedge clk);
    check({q_b1, q_b2, q_b3, q_b4} == 8'h00, "R10 reset outputs", {q_b1, q_b2, q_b3, q_b4}, 0);

    // table of vectors: rising-edge position and duty for every bank
    for (int v = 0; v < NVEC; v++) begin
      logic [83:0] e;
      int mf;
      e = VECS[v];
      start(e[83:82], e[81:80], 1'b0, e[79:76], e[75:72], e[71:68], e[67:64]);
      pair_bad = 0;
      for (int k = 0; k < NSMP; k++) begin
        @(negedge clk);
        grab(k);   // sample k shows phase position k
      end
      case (e[83:82])
        2'b00:   mf = 32;
        2'b10:   mf = 8;
        default: mf = 16;
      endcase
      check(pair_bad == 0, "R1 output pair mismatch", pair_bad, 0);
      for (int b = 0; b < 4; b++) begin
        int p, r, found, highs;
        p = int'(e[63-16*b -: 8]);
        r = int'(e[55-16*b -: 8]);
        found = -1; highs = 0;
        for (int t = p; t < 2*p; t++) begin
          if (!smp[t-1][b] && smp[t][b] && found < 0) found = t - p;
          if (smp[t][b]) highs++;
        end
        check(found == r, $sformatf("%s vec %0d bank %0d rise", tag_of(e[81:80], b, p, mf), v, b+1), found, r);
        check(highs == p/2, $sformatf("R2 vec %0d bank %0d duty", v, b+1), highs, p/2);
      end
    end

    // R7: a bank code changed in mid-cycle is held until the cycle ends
    start(2'b01, 2'b10, 1'b0, 4'b0101, 4'b0101, 4'b0101, 4'b0101);
    for (int k = 0; k <= 40; k++) begin
      @(negedge clk);
      grab(k);
      if (k == 20) sel_b1 = 4'b1010;
    end
    for (int t = 24; t < 28; t++)
      check(smp[t][0] == 1'b0, $sformatf("R7 held old skew t=%0d", t), smp[t][0], 0);
    check(smp[32][0] == 1'b0, "R7 new skew t=32", smp[32][0], 0);
    check(smp[36][0] == 1'b1, "R7 new skew t=36", smp[36][0], 1);

    // R9: bypass with divide-by-4 on bank 3 and divide-by-2 on bank 4
    start(2'b01, 2'b10, 1'b1, 4'b0101, 4'b0101, 4'b1010, 4'b0000);
    for (int n = 1; n <= 4; n++) begin
      ref_in = 1'b1;
      @(negedge clk);
      check(q_b1 == 2'b11 && q_b2 == 2'b11, $sformatf("R9 follow high rise %0d", n), q_b1, 3);
      check(q_b3 == {2{n[1]}}, $sformatf("R9 bank3 K=4 rise %0d", n), q_b3, {2{n[1]}});
      check(q_b4 == {2{n[0]}}, $sformatf("R9 bank4 M=2 rise %0d", n), q_b4, {2{n[0]}});
      ref_in = 1'b0;
      @(negedge clk);
      check(q_b1 == 2'b00, $sformatf("R9 follow low %0d", n), q_b1, 0);
      check(q_b3 == {2{n[1]}}, $sformatf("R9 bank3 hold %0d", n), q_b3, {2{n[1]}});
      @(negedge clk);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule